// File: doc/BRIEF.md
# Clock-Stop SPI Master Sequencer

This block runs one SPI master word transfer at a time. Between words the serial clock is parked at its high level and makes no edges. When a transfer starts, an active-low slave select goes low and the first data bit is driven at once. After half a serial period the clock makes its first falling edge. Each later bit is shifted out, most significant bit first, on a falling edge. The receive line is sampled on every rising edge.

After the last rising edge the data output is released (its enable drops) half a period later. The select line is held low for one full period after that rising edge and then goes high. The received word is then presented together with a one-cycle done pulse.

The serial clock comes from an internal divider that is held in reset between words. Its half period is `HALF_CYC` system clocks, and the word length is `WORD_W`. The host side is a start strobe, a parallel transmit word, a busy flag, a parallel receive word and the done pulse.

Top module: `spim_seq`

## Requirements
- R1: After a synchronous active-low reset: `ssn_o`=1, `sclk_o`=1, `sdo_oe_o`=0, `sdo_o`=0, `busy_o`=0, `done_o`=0.
- R2: A `start_i` seen high on a clock edge while `busy_o`=0 starts a transfer. In the next cycle `ssn_o`=0, `sdo_oe_o`=1 and `busy_o`=1, `sdo_o` carries bit `WORD_W-1` of `tx_word_i`, and `sclk_o` is still 1.
- R3: The first falling edge of `sclk_o` occurs `HALF_CYC` system cycles after `ssn_o` falls.
- R4: For each bit, `sclk_o` is low for `HALF_CYC` cycles and then high for `HALF_CYC` cycles. `sdo_o` changes only together with a falling edge. Bits go out in order from bit `WORD_W-1` down to bit 0.
- R5: `sdi_i` is sampled on the system edge at which `sclk_o` rises. The first sample lands in bit `WORD_W-1` of `rx_word_o` and the last in bit 0.
- R6: `sdo_oe_o` falls `HALF_CYC` cycles after the last rising edge of `sclk_o`.
- R7: `ssn_o` rises `2*HALF_CYC` cycles after the last rising edge of `sclk_o`. In that same cycle `done_o` is 1 for exactly one cycle, `busy_o` returns to 0 and `rx_word_o` holds the received word.
- R8: `start_i` and changes to `tx_word_i` while `busy_o`=1 are ignored. The running transfer keeps its timing and transmit data.
- R9: Whenever `ssn_o` is 1, `sclk_o` is 1, so there are no clock edges between words.
- R10: `sdo_o` reads 0 whenever `sdo_oe_o` is 0, and `sdo_oe_o` is 1 only while `ssn_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to start a word transfer |
| tx_word_i | input | WORD_W | Word to send, taken when a start is accepted |
| busy_o | output | 1 | A transfer is in progress |
| rx_word_o | output | WORD_W | Last received word |
| done_o | output | 1 | One-cycle pulse when a word completes |
| sclk_o | output | 1 | Serial clock, idles high |
| ssn_o | output | 1 | Slave select, active low |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data pin |
| sdi_i | input | 1 | Serial data in |

## Verification
The assertions assume `HALF_CYC` is at least 1 and `WORD_W` is at least 2. They also assume `sdi_i` is a synchronous level that is stable at the system edge where it is sampled, and that `start_i` is a clean synchronous strobe. The stimulus changes every input only on the falling system-clock edge, so no sampling edge sees an input moving. It holds `sdi_i` at the bit meant for the next rising serial edge, and raises a stray start only in the middle of a transfer, never in its final cycle.

// File: rtl/spim_pkg.sv
// Shared types for the clock-stop SPI master sequencer.
// Assumes nothing beyond a SystemVerilog-2017 compiler.
package spim_pkg;

    // Sequencer phases of one word transfer
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // select high, clock parked high
        ST_LEAD = 3'd1,  // select low, first bit out, waiting half period
        ST_LOW  = 3'd2,  // serial clock low phase
        ST_HIGH = 3'd3,  // serial clock high phase
        ST_TAIL = 3'd4   // data released, select still held low
    } spim_state_t;

endpackage

// File: rtl/spim_tick.sv
// Half-period strobe generator for the serial clock.
// Emits one-cycle tick every HALF_CYC system cycles while run is high;
// the count restarts from zero whenever run is low, so the first tick
// of a transfer comes exactly HALF_CYC cycles after run rises.
module spim_tick #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Count system cycles within the current half period
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Strobe at the end of each half period
    always_comb tick = run && (cnt == LAST);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R9
    tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/spim_shifter.sv
// Transmit and receive shift registers.
// Loads the transmit word on load, moves it one place toward the MSB
// on shift, and appends the sampled input bit on capture. The receive
// shifter is copied to the parallel output on finish.
module spim_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              shift,
    input  logic              capture,
    input  logic              finish,
    input  logic              sdi,
    output logic              tx_bit,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;

    // Transmit shifter: load on accept, advance on each falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (load) begin
            tx_sh <= tx_word;
        end else if (shift) begin
            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
        end
    end

    // Receive shifter: append the input bit on each rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh <= '0;
        end else if (capture) begin
            rx_sh <= {rx_sh[WORD_W-2:0], sdi};
        end
    end

    // Parallel receive word, updated when the word completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (finish) begin
            rx_word <= rx_sh;
        end
    end

    always_comb tx_bit = tx_sh[WORD_W-1];

    // R4
    no_load_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

    // R5
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(rx_word));

endmodule

// File: rtl/spim_fsm.sv
// Phase sequencer for one word transfer.
// Drives select, serial clock, output enable and done, and tells the
// shifter when to load, shift and capture. Assumes tick pulses once per
// half serial period while busy, and WORD_W >= 2.
module spim_fsm
    import spim_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic load,
    output logic shift,
    output logic capture,
    output logic finish,
    output logic busy,
    output logic sclk,
    output logic ssn,
    output logic oe,
    output logic done
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    spim_state_t      st;
    logic [BIT_W-1:0] bit_idx;
    logic             last_bit;

    // Strobes derived from the current phase
    always_comb begin
        last_bit = (bit_idx == LAST_BIT);
        busy     = (st != ST_IDLE);
        load     = start && (st == ST_IDLE);
        capture  = tick && (st == ST_LOW);
        shift    = tick && (st == ST_HIGH) && !last_bit;
        finish   = tick && (st == ST_TAIL);
    end

    // Phase register and registered pin levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            bit_idx <= '0;
            sclk    <= 1'b1;
            ssn     <= 1'b1;
            oe      <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    st      <= ST_LEAD;
                    ssn     <= 1'b0;
                    oe      <= 1'b1;
                    bit_idx <= '0;
                end
                ST_LEAD: if (tick) begin
                    st   <= ST_LOW;
                    sclk <= 1'b0;
                end
                ST_LOW: if (tick) begin
                    st   <= ST_HIGH;
                    sclk <= 1'b1;
                end
                ST_HIGH: if (tick) begin
                    if (last_bit) begin
                        st <= ST_TAIL;
                        oe <= 1'b0;
                    end else begin
                        st      <= ST_LOW;
                        sclk    <= 1'b0;
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                ST_TAIL: if (tick) begin
                    st   <= ST_IDLE;
                    ssn  <= 1'b1;
                    done <= 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R9
    idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ssn |-> sclk);

    // R10
    oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !ssn);

    // R2
    select_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ssn) |-> (sclk && oe));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_with_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(ssn));

    // R8
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !$fell(ssn));

    // R4
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= LAST_BIT);

endmodule

// File: rtl/spim_seq.sv
// Clock-stop SPI master sequencer, top level.
// Connects the half-period strobe generator, the phase sequencer and the
// shift registers. Assumes sdi_i is synchronous to clk, HALF_CYC >= 1 and
// WORD_W >= 2. sdo_o is forced to 0 while its enable is low.
module spim_seq #(
    parameter int WORD_W   = 8,
    parameter int HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] tx_word_i,
    output logic              busy_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              done_o,
    output logic              sclk_o,
    output logic              ssn_o,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    input  logic              sdi_i
);
    logic tick;
    logic load;
    logic shift;
    logic capture;
    logic finish;
    logic busy;
    logic oe;
    logic tx_bit;

    spim_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    spim_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .tick    (tick),
        .load    (load),
        .shift   (shift),
        .capture (capture),
        .finish  (finish),
        .busy    (busy),
        .sclk    (sclk_o),
        .ssn     (ssn_o),
        .oe      (oe),
        .done    (done_o)
    );

    spim_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .tx_word (tx_word_i),
        .shift   (shift),
        .capture (capture),
        .finish  (finish),
        .sdi     (sdi_i),
        .tx_bit  (tx_bit),
        .rx_word (rx_word_o)
    );

    // Pin-level outputs
    always_comb begin
        busy_o   = busy;
        sdo_oe_o = oe;
        sdo_o    = oe & tx_bit;
    end

    // R10
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe_o |-> !sdo_o);

    // R4
    sdo_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe_o && $past(sdo_oe_o) && !$fell(sclk_o)) |-> $stable(sdo_o));

endmodule

// File: tb/sim_spim_seq.sv
// Directed bench for spim_seq: one task per scenario, each checks itself.
module sim_spim_seq;
    localparam int W = 8;
    localparam int H = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] tx_word_i = '0;
    logic         sdi_i = 1'b0;
    logic         busy_o, done_o, sclk_o, ssn_o, sdo_o, sdo_oe_o;
    logic [W-1:0] rx_word_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    spim_seq #(.WORD_W(W), .HALF_CYC(H)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_word_i(tx_word_i),
        .busy_o(busy_o), .rx_word_o(rx_word_o), .done_o(done_o),
        .sclk_o(sclk_o), .ssn_o(ssn_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
        .sdi_i(sdi_i)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "ssn", ssn_o, 1); chk("R1", "sclk", sclk_o, 1);
        chk("R1", "oe", sdo_oe_o, 0); chk("R1", "sdo", sdo_o, 0);
        chk("R1", "busy", busy_o, 0); chk("R1", "done", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R9, R10: no activity between words
    task automatic t_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R9", "idle sclk", sclk_o, 1);
            chk("R9", "idle ssn", ssn_o, 1);
            chk("R10", "idle oe", sdo_oe_o, 0);
            chk("R10", "idle sdo", sdo_o, 0);
            chk("R7", "idle done", done_o, 0);
        end
    endtask

    // R2..R8: one word, optional stray start at sample inj
    task automatic t_word(input logic [W-1:0] tx, input logic [W-1:0] rxp,
                          input int inj);
        int kr;
        int kend;
        kr   = 2 * H * W;
        kend = kr + 2 * H;
        @(negedge clk);
        start_i   = 1'b1;
        tx_word_i = tx;
        for (int k = 0; k <= kend; k++) begin
            logic e_sclk, e_oe, e_ssn, e_bit;
            int   b;
            int   e;
            @(negedge clk);
            if (k < H) begin
                e_sclk = 1'b1; e_bit = tx[W-1];
            end else if (k < kr) begin
                b = (k - H) / (2 * H);
                e_sclk = (((k - H) % (2 * H)) >= H);
                e_bit  = tx[W-1-b];
            end else begin
                e_sclk = 1'b1; e_bit = tx[0];
            end
            e_oe  = (k < kr + H);
            e_ssn = (k == kend);
            if (k == 0) begin
                chk("R2", "ssn low", ssn_o, 0);
                chk("R2", "oe high", sdo_oe_o, 1);
                chk("R2", "busy", busy_o, 1);
            end
            chk(k <= H ? "R3" : "R4", "sclk", sclk_o, e_sclk);
            chk("R4", "sdo", sdo_o, e_oe ? e_bit : 1'b0);
            chk("R6", "oe", sdo_oe_o, e_oe);
            chk("R7", "ssn", ssn_o, e_ssn);
            chk("R7", "done", done_o, (k == kend));
            chk(k > inj && inj >= 0 ? "R8" : "R7", "busy", busy_o, (k != kend));
            if (k == kend) chk("R5", "rx_word", rx_word_o, rxp);
            // next inputs
            start_i   = (k == inj);
            tx_word_i = (k == inj) ? ~tx : tx;
            e = k + 1;
            b = (e < H) ? 0 : (e - H) / (2 * H);
            if (b > W - 1) b = W - 1;
            sdi_i = rxp[W-1-b];
        end
        start_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_idle(3);
        t_word(8'hA5, 8'h3C, -1);
        t_idle(4);
        t_word(8'h00, 8'hFF, -1);
        t_word(8'hFF, 8'h00, 9);
        t_idle(2);
        t_word(8'h81, 8'h7E, 20);
        t_word(8'h5A, 8'hC3, -1);
        t_idle(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule